// File: doc/BRIEF.md
# Gated Virtual Offset Register Bank

The block keeps sixteen 64-bit virtual offset values and serves them through a system-register style request port. Each request carries the five encoding fields, a read/write flag, write data and the privilege level (0 to 3) of the requester. The block first decides whether the encoding belongs to it. It then runs a prioritised, privilege-dependent decision chain that settles on one outcome: undefined, trap to level 2, trap to level 3, redirect to memory, or direct register access.

Static configuration inputs steer the chain. They say whether the feature exists, how many monitors are implemented, which indices carry an offset, and the state of the nested-virtualisation control bits. Further inputs say whether levels 2 and 3 exist and give the level-3 enable and trap controls and the two undefined-priority flags. The answer comes back one cycle after the request. It carries a code, read data, a syndrome class for traps and a memory address for redirected accesses. The memory access itself and the delivery of exceptions belong to the surrounding logic.

Top module: `voff_bank_top`

## Requirements
- R1: A request belongs to the block only when op0=3, op1=4, CRn=13 and CRm[3:1]=3'b101. Any other request returns code NOT_MINE (5) and leaves every register unchanged.
- R2: The register index is {CRm[0], op2[2:0]}, with CRm[0] as the most significant bit.
- R3: The outcome is UNDEF (1) when the feature is absent, when the index is not below the implemented monitor count, or when the mask bit for the index is clear. This holds at every privilege level, including level 3.
- R4: An owned request from privilege level 0 that passes R3 returns UNDEF.
- R5: At level 1 there are three cases. When nested-virtualisation bits 2 and 0 are both set, the code is NV_MEM (4) with address 0xA80 + 8*index. Otherwise, when bit 0 is set, the code is TRAP_L2 (2) with syndrome class 0x18. Otherwise the code is UNDEF.
- R6: At level 2 with level 3 present, the checks run in this order. First, with the priority flag set, a trap bit of 1 gives UNDEF, and then an enable bit of 0 gives UNDEF. Next, an enable bit of 0 gives UNDEF if the debug-undefined flag is set and TRAP_L3 (3) with class 0x18 if it is not. Next, a trap bit of 1 is handled the same way. Only after all of these does the access proceed as OK (0).
- R7: At level 2 without level 3, and at level 3, the access is OK. A write updates the selected register on the clock edge that ends the request, and a later read returns the value written. Reads and writes go through the same decision chain.
- R8: When level 2 is not implemented, an OK access reads zero and its write is discarded.
- R9: The response is valid exactly one cycle after a request. Read data is zero unless the outcome is a read with code OK. The address is zero unless the code is NV_MEM. The syndrome is zero unless the code is TRAP_L2 or TRAP_L3.
- R10: After reset every register holds zero, and the response outputs read zero with valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 64 | Write data |
| req_el | input | 2 | Privilege level of the requester |
| cfg_feat_en | input | 1 | Feature present |
| cfg_num_mon | input | 5 | Number of implemented monitors (0 to 16) |
| cfg_impl_mask | input | 16 | Per-index offset present |
| cfg_nv | input | 3 | Nested-virtualisation control bits |
| cfg_has_l2 | input | 1 | Level 2 implemented |
| cfg_has_l3 | input | 1 | Level 3 implemented |
| cfg_l3_en | input | 1 | Level-3 enable for offset access |
| cfg_l3_trap | input | 1 | Level-3 trap control |
| cfg_undef_prio | input | 1 | Undefined-priority flag |
| cfg_dbg_undef | input | 1 | Debug-undefined flag |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 3 | Outcome code |
| rsp_rdata | output | 64 | Read data |
| rsp_addr | output | 12 | Memory address for redirected accesses |
| rsp_syn | output | 6 | Trap syndrome class |

## Verification
The assertions assume that req_valid is a single-cycle strobe. They also assume that the configuration inputs do not change between a request and its response, because the checks on the code relate the request-side inputs at one edge to the response at the next. The bench changes configuration only while no request is in flight. It drives each request at the falling edge and drops it one step after the rising edge. The sweeps cover every privilege level, every nested-virtualisation pattern and every combination of the level-3 controls, the monitor count and the mask, so each arm of the chain is reached with many indices.

// File: rtl/voff_pkg.sv
package voff_pkg;

  typedef enum logic [2:0] {
    VO_OK       = 3'd0,
    VO_UNDEF    = 3'd1,
    VO_TRAP_EL2 = 3'd2,
    VO_TRAP_EL3 = 3'd3,
    VO_MEM      = 3'd4,
    VO_FOREIGN  = 3'd5
  } vo_outcome_e;

  localparam logic [5:0] VO_TRAP_CLASS = 6'h18;

endpackage

// File: rtl/voff_decode.sv
module voff_decode #(
  parameter int IDX_W = 4
) (
  input  logic [1:0]       op0,
  input  logic [2:0]       op1,
  input  logic [3:0]       crn,
  input  logic [3:0]       crm,
  input  logic [2:0]       op2,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  // Ownership depends on the fixed encoding only.
  always_comb begin
    hit = (op0 == 2'b11) && (op1 == 3'b100) && (crn == 4'hD) && (crm[3:1] == 3'b101);
    idx = IDX_W'({crm[0], op2});
  end

endmodule

// File: rtl/voff_policy.sv
module voff_policy
  import voff_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 4,
  parameter int CNT_W    = 5
) (
  input  logic                hit,
  input  logic [IDX_W-1:0]    idx,
  input  logic [1:0]          el,
  input  logic                feat_en,
  input  logic [CNT_W-1:0]    num_mon,
  input  logic [NUM_REGS-1:0] impl_mask,
  input  logic [2:0]          nv,
  input  logic                has_l3,
  input  logic                l3_en,
  input  logic                l3_trap,
  input  logic                undef_prio,
  input  logic                dbg_undef,
  output vo_outcome_e         outcome
);

  logic        present;
  vo_outcome_e l3_gate;

  always_comb begin
    present = feat_en && (CNT_W'(idx) < num_mon) && impl_mask[idx];
  end

  // Level-2 path when level 3 exists: the priority flag checks come first.
  always_comb begin
    if (undef_prio && l3_trap)      l3_gate = VO_UNDEF;
    else if (undef_prio && !l3_en)  l3_gate = VO_UNDEF;
    else if (!l3_en)                l3_gate = dbg_undef ? VO_UNDEF : VO_TRAP_EL3;
    else if (l3_trap)               l3_gate = dbg_undef ? VO_UNDEF : VO_TRAP_EL3;
    else                            l3_gate = VO_OK;
  end

  always_comb begin
    if (!hit) begin
      outcome = VO_FOREIGN;
    end else if (!present) begin
      outcome = VO_UNDEF;
    end else begin
      unique case (el)
        2'd0: outcome = VO_UNDEF;
        2'd1: begin
          if (nv[2] && nv[0])  outcome = VO_MEM;
          else if (nv[0])      outcome = VO_TRAP_EL2;
          else                 outcome = VO_UNDEF;
        end
        2'd2:    outcome = has_l3 ? l3_gate : VO_OK;
        default: outcome = VO_OK;
      endcase
    end
  end

endmodule

// File: rtl/voff_regfile.sv
module voff_regfile #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 64,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] bank_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    logic              ld;
    logic [DATA_W-1:0] slot_d;

    always_comb begin
      ld     = wr_en && (wr_idx == IDX_W'(g));
      slot_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bank_q[g] <= '0;
      else if (ld)  bank_q[g] <= slot_d;
    end
  end

  always_comb begin
    rd_data = bank_q[rd_idx];
  end

endmodule

// File: rtl/voff_bank_top.sv
module voff_bank_top
  import voff_pkg::*;
#(
  parameter int              NUM_REGS = 16,
  parameter int              DATA_W   = 64,
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] NV_BASE = 12'hA80,
  localparam int             IDX_W    = $clog2(NUM_REGS),
  localparam int             CNT_W    = $clog2(NUM_REGS + 1),
  localparam int             STRIDE_SH = $clog2(DATA_W / 8)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_op0,
  input  logic [2:0]          req_op1,
  input  logic [3:0]          req_crn,
  input  logic [3:0]          req_crm,
  input  logic [2:0]          req_op2,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [1:0]          req_el,
  input  logic                cfg_feat_en,
  input  logic [CNT_W-1:0]    cfg_num_mon,
  input  logic [NUM_REGS-1:0] cfg_impl_mask,
  input  logic [2:0]          cfg_nv,
  input  logic                cfg_has_l2,
  input  logic                cfg_has_l3,
  input  logic                cfg_l3_en,
  input  logic                cfg_l3_trap,
  input  logic                cfg_undef_prio,
  input  logic                cfg_dbg_undef,
  output logic                rsp_valid,
  output logic [2:0]          rsp_code,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   rsp_addr,
  output logic [5:0]          rsp_syn
);

  // Reset synchroniser: asserts asynchronously, releases on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_sync_n = rst_pipe_q[1];

  logic              enc_hit;
  logic [IDX_W-1:0]  enc_idx;
  vo_outcome_e       verdict;
  logic              live;
  logic              bank_we;
  logic [DATA_W-1:0] bank_rd;

  voff_decode #(.IDX_W(IDX_W)) u_dec (
    .op0 (req_op0),
    .op1 (req_op1),
    .crn (req_crn),
    .crm (req_crm),
    .op2 (req_op2),
    .hit (enc_hit),
    .idx (enc_idx)
  );

  voff_policy #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pol (
    .hit        (enc_hit),
    .idx        (enc_idx),
    .el         (req_el),
    .feat_en    (cfg_feat_en),
    .num_mon    (cfg_num_mon),
    .impl_mask  (cfg_impl_mask),
    .nv         (cfg_nv),
    .has_l3     (cfg_has_l3),
    .l3_en      (cfg_l3_en),
    .l3_trap    (cfg_l3_trap),
    .undef_prio (cfg_undef_prio),
    .dbg_undef  (cfg_dbg_undef),
    .outcome    (verdict)
  );

  // The bank is touched only by an accepted direct access with level 2 present.
  always_comb begin
    live    = req_valid && (verdict == VO_OK) && cfg_has_l2;
    bank_we = live && req_write;
  end

  voff_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (bank_we),
    .wr_idx  (enc_idx),
    .wr_data (req_wdata),
    .rd_idx  (enc_idx),
    .rd_data (bank_rd)
  );

  // Response stage: next-state logic.
  logic              valid_d, valid_q;
  logic [2:0]        code_d, code_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [5:0]        syn_d, syn_q;

  always_comb begin
    valid_d = req_valid;
    code_d  = verdict;
    rdata_d = (live && !req_write) ? bank_rd : '0;
    addr_d  = (verdict == VO_MEM) ? (NV_BASE + (ADDR_W'(enc_idx) << STRIDE_SH)) : '0;
    syn_d   = (verdict == VO_TRAP_EL2 || verdict == VO_TRAP_EL3) ? VO_TRAP_CLASS : 6'h00;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
      rdata_q <= '0;
      addr_q  <= '0;
      syn_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (req_valid) begin
        code_q  <= code_d;
        rdata_q <= rdata_d;
        addr_q  <= addr_d;
        syn_q   <= syn_d;
      end
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_code  = code_q;
  assign rsp_rdata = rdata_q;
  assign rsp_addr  = addr_q;
  assign rsp_syn   = syn_q;

endmodule

// File: rtl/voff_bank_chk.sv
module voff_bank_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              req_valid,
  input logic [1:0]        req_op0,
  input logic [2:0]        req_op1,
  input logic [3:0]        req_crn,
  input logic [3:0]        req_crm,
  input logic [1:0]        req_el,
  input logic              cfg_feat_en,
  input logic              rsp_valid,
  input logic [2:0]        rsp_code,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [5:0]        rsp_syn
);

  logic owned;
  assign owned = (req_op0 == 2'b11) && (req_op1 == 3'b100) && (req_crn == 4'hD) && (req_crm[3:1] == 3'b101);

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);

  // R9
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid);

  // R9
  rdata_gated_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && rsp_code != 3'd0) |-> (rsp_rdata == '0));

  // R1
  foreign_code_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !owned) |=> (rsp_code == 3'd5));

  // R3
  feature_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && owned && !cfg_feat_en) |=> (rsp_code == 3'd1));

  // R4
  level0_undef_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && owned && req_el == 2'd0) |=> (rsp_code == 3'd1));

  // R5
  mem_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && rsp_code == 3'd4) |->
      (rsp_addr[2:0] == 3'b000 && rsp_addr >= ADDR_W'(12'hA80) && rsp_addr <= ADDR_W'(12'hAF8)));

  // R9
  addr_gated_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && rsp_code != 3'd4) |-> (rsp_addr == '0));

  // R5
  syn_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> ((rsp_code == 3'd2 || rsp_code == 3'd3) ? (rsp_syn == 6'h18) : (rsp_syn == 6'h00)));

endmodule

bind voff_bank_top voff_bank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_voff_bank_top.sv
module sim_voff_bank_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op0;
  logic [2:0]  req_op1;
  logic [3:0]  req_crn;
  logic [3:0]  req_crm;
  logic [2:0]  req_op2;
  logic        req_write;
  logic [63:0] req_wdata;
  logic [1:0]  req_el;
  logic        cfg_feat_en;
  logic [4:0]  cfg_num_mon;
  logic [15:0] cfg_impl_mask;
  logic [2:0]  cfg_nv;
  logic        cfg_has_l2, cfg_has_l3, cfg_l3_en, cfg_l3_trap, cfg_undef_prio, cfg_dbg_undef;
  logic        rsp_valid;
  logic [2:0]  rsp_code;
  logic [63:0] rsp_rdata;
  logic [11:0] rsp_addr;
  logic [5:0]  rsp_syn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [63:0] model [16];

  voff_bank_top u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] pat(int m, int salt);
    return {32'(m * 32'h0101_0101 + salt), 32'(32'hC0DE_0000 ^ (m << 4) ^ salt)};
  endfunction

  // Expected outcome, written from the requirement text.
  function automatic logic [2:0] want_code(logic own, int m, int el);
    if (!own) return 3'd5;                                      // R1
    if (!cfg_feat_en || m >= int'(cfg_num_mon) || !cfg_impl_mask[m]) return 3'd1; // R3
    case (el)
      0: return 3'd1;                                           // R4
      1: begin                                                  // R5
        if (cfg_nv[0] && cfg_nv[2]) return 3'd4;
        if (cfg_nv[0]) return 3'd2;
        return 3'd1;
      end
      2: begin                                                  // R6
        if (!cfg_has_l3) return 3'd0;
        if (cfg_undef_prio && (cfg_l3_trap || !cfg_l3_en)) return 3'd1;
        if (!cfg_l3_en || cfg_l3_trap) return cfg_dbg_undef ? 3'd1 : 3'd3;
        return 3'd0;
      end
      default: return 3'd0;
    endcase
  endfunction

  task automatic issue(input logic [1:0] o0, input logic [2:0] o1, input logic [3:0] cn,
                       input logic [3:0] cm, input logic [2:0] o2, input logic wr,
                       input logic [63:0] wd, input logic [1:0] el);
    @(negedge clk);
    req_valid = 1'b1; req_op0 = o0; req_op1 = o1; req_crn = cn; req_crm = cm; req_op2 = o2;
    req_write = wr; req_wdata = wd; req_el = el;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  // Owned access with model tracking and full response check.
  task automatic access(input string tag, input int m, input logic wr, input logic [63:0] wd, input int el);
    logic [2:0]  ec;
    logic [63:0] ed;
    logic [11:0] ea;
    logic [5:0]  es;
    ec = want_code(1'b1, m, el);
    ed = (ec == 3'd0 && !wr && cfg_has_l2) ? model[m] : 64'd0;       // R8, R9
    ea = (ec == 3'd4) ? 12'(12'hA80 + 8 * m) : 12'd0;                 // R5
    es = (ec == 3'd2 || ec == 3'd3) ? 6'h18 : 6'h00;
    issue(2'b11, 3'b100, 4'hD, {3'b101, 1'(m >> 3)}, 3'(m), wr, wd, 2'(el));
    if (ec == 3'd0 && wr && cfg_has_l2) model[m] = wd;                // R7
    checks++;
    if (!rsp_valid || rsp_code !== ec || rsp_rdata !== ed || rsp_addr !== ea || rsp_syn !== es) begin
      errors++;
      $display("FAIL %s m=%0d el=%0d wr=%0d: actual v=%0b code=%0d data=%h addr=%h syn=%h, expected v=1 code=%0d data=%h addr=%h syn=%h",
               tag, m, el, wr, rsp_valid, rsp_code, rsp_rdata, rsp_addr, rsp_syn, ec, ed, ea, es);
    end
  endtask

  task automatic cfg_open();
    cfg_feat_en = 1; cfg_num_mon = 5'd16; cfg_impl_mask = 16'hFFFF; cfg_nv = 3'b000;
    cfg_has_l2 = 1; cfg_has_l3 = 1; cfg_l3_en = 1; cfg_l3_trap = 0; cfg_undef_prio = 0; cfg_dbg_undef = 0;
  endtask

  task automatic verify_bank(input string tag);
    for (int m = 0; m < 16; m++) access(tag, m, 1'b0, 64'd0, 3);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_op0 = 0; req_op1 = 0; req_crn = 0; req_crm = 0; req_op2 = 0;
    req_write = 0; req_wdata = 0; req_el = 0;
    cfg_open();
    for (int m = 0; m < 16; m++) model[m] = 64'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    #1;

    // R10: response outputs after reset
    checks++;
    if (rsp_valid !== 0 || rsp_code !== 0 || rsp_rdata !== 0 || rsp_addr !== 0 || rsp_syn !== 0) begin
      errors++;
      $display("FAIL R10 reset outputs: actual v=%0b code=%0d data=%h, expected all zero", rsp_valid, rsp_code, rsp_rdata);
    end
    verify_bank("R10 reset contents");

    // R7, R2: fill each slot from level 3 and level 2 without level 3, then read back
    for (int m = 0; m < 16; m++) access("R7 write el3", m, 1'b1, pat(m, 1), 3);
    verify_bank("R7 R2 readback");
    cfg_has_l3 = 0;
    for (int m = 0; m < 16; m += 3) access("R7 write el2 no l3", m, 1'b1, pat(m, 7), 2);
    for (int m = 0; m < 16; m++) access("R7 read el2 no l3", m, 1'b0, 64'd0, 2);
    cfg_open();

    // R4 R5 R6: sweep privilege, nested bits and level-3 controls, reads and writes
    for (int el = 0; el < 4; el++)
      for (int nv = 0; nv < 8; nv++)
        for (int f = 0; f < 32; f++) begin
          cfg_nv = 3'(nv);
          cfg_has_l3 = f[0]; cfg_l3_en = f[1]; cfg_l3_trap = f[2];
          cfg_undef_prio = f[3]; cfg_dbg_undef = f[4];
          access("R4 R5 R6 chain", (el * 7 + nv * 3 + f) % 16, 1'((nv + f) % 3 == 0),
                 pat(f, nv + el), el);
        end
    cfg_open();
    verify_bank("R6 bank after chain sweep");

    // R3: monitor count and mask, at every level including 3
    for (int n = 0; n <= 16; n++) begin
      cfg_num_mon = 5'(n);
      for (int m = 0; m < 16; m++) access("R3 count", m, 1'b0, 64'd0, 3);
    end
    cfg_num_mon = 5'd16;
    cfg_impl_mask = 16'hA5C3;
    for (int m = 0; m < 16; m++) access("R3 mask", m, 1'b1, pat(m, 99), m % 4);
    cfg_impl_mask = 16'hFFFF;
    cfg_feat_en = 0;
    for (int el = 0; el < 4; el++) access("R3 feature off", el * 5, 1'b1, pat(el, 55), el);
    cfg_open();
    verify_bank("R3 bank unchanged");

    // R1: foreign encodings, writes must not land
    begin
      logic [1:0] o0s [5] = '{2'b10, 2'b11, 2'b11, 2'b11, 2'b11};
      logic [2:0] o1s [5] = '{3'b100, 3'b011, 3'b100, 3'b100, 3'b100};
      logic [3:0] cns [5] = '{4'hD, 4'hD, 4'hC, 4'hD, 4'hD};
      logic [3:0] cms [5] = '{4'hA, 4'hB, 4'hA, 4'h8, 4'hE};
      for (int k = 0; k < 5; k++) begin
        issue(o0s[k], o1s[k], cns[k], cms[k], 3'(k), 1'b1, 64'hDEAD_BEEF_0000_0000 + 64'(k), 2'd3);
        checks++;
        if (rsp_code !== 3'd5 || rsp_rdata !== 0 || rsp_syn !== 0 || rsp_addr !== 0) begin
          errors++;
          $display("FAIL R1 foreign %0d: actual code=%0d data=%h, expected code=5 data=0", k, rsp_code, rsp_rdata);
        end
      end
    end
    verify_bank("R1 bank unchanged");

    // R8: level 2 absent -> reads zero, writes dropped
    cfg_has_l2 = 0;
    for (int m = 0; m < 16; m += 2) access("R8 write dropped", m, 1'b1, pat(m, 3), 3);
    for (int m = 0; m < 16; m++) access("R8 read zero", m, 1'b0, 64'd0, 3);
    cfg_has_l2 = 1;
    verify_bank("R8 bank kept");

    // R9: idle cycle gives no response
    @(posedge clk);
    #1;
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 idle: actual valid=%0b, expected 0", rsp_valid);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule